// File: doc/BRIEF.md
# Chip-Select Address Decoder

This block sits in front of an external system bus and turns each incoming 32-bit bus address into a single chip-select line. It holds a small register file written over a plain 32-bit register port. Eight bank registers each describe one address window in 128 KiB granules: a base, a per-bit compare mask and an enable bit. Five more words are plain storage for bank timing parameters and have no effect on decoding.

A strap sampled during reset can exchange chip selects 0 and 1, so that a boot device wired to the second select is reached first. The strap's state can be read back from bank register 0 after reset. Banks 0 and 1 also have a special case. A register value of exactly zero in either of them claims the whole address space, whatever its enable bit says. To park one of these two banks, software writes all ones to it, which leaves it matching only the topmost granule.

Each address is presented with a valid strobe. One cycle later the block gives a one-hot chip select, the index of that select, a hit flag, and a one-cycle error pulse for an address that no bank claims.

Top module: `csel_decoder`

## Requirements
- R1: While reset is held, bank register 0 is set to 0x00000001 if the strap is low and to 0x00000000 if it is high. Every other bank register and timing word resets to zero, and all decode outputs are low.
- R2: Bank register i is at byte offset 0x100 + 0x10*i. The five timing words are at 0x200, 0x204, 0x208, 0x20C and 0x300. All of these are read and written as full 32-bit words. Any other offset reads zero, and writes to it change nothing.
- R3: Bank register fields are laid out as follows:
  - bits 31:17 hold the base;
  - bits 15:1 hold the mask, where mask bit k governs address bit 17+k;
  - bit 0 is the enable.

  A bank matches when it is enabled and every address bit whose mask bit is 1 equals the corresponding base bit. Address bits whose mask bit is 0 are ignored.
- R4: A bank whose enable bit is 0 never matches. The only exception is the R5 case.
- R5: If bank register 0 or 1 holds exactly 0x00000000, that bank matches every address.
- R6: When several banks match, the lowest-numbered bank register wins.
- R7: The strap is captured only while reset is held. When it was high, bank register 0 drives chip select 1 and bank register 1 drives chip select 0. The index output always gives the number of the chip select that is asserted.
- R8: Decode outputs are registered in the clock edge that follows the valid strobe. In the cycle after a clock with valid low, every decode output is low.
- R9: A valid address that no bank matches gives hit 0, no chip select, and a decode-error pulse in that one result cycle only.
- R10: At most one chip select is high. When hit is 1, the index names the asserted select. When hit is 0, the index is 0.
- R11: Writing the timing words leaves the decode result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the strap is sampled while it is low |
| boot_swap_i | input | 1 | Strap that exchanges chip selects 0 and 1 |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational from offset) |
| addr_valid_i | input | 1 | Bus address valid |
| addr_i | input | 32 | Bus address |
| cs_o | output | NBANK | One-hot chip selects |
| cs_idx_o | output | clog2(NBANK) | Number of the asserted chip select |
| hit_o | output | 1 | Address claimed by a bank |
| dec_err_o | output | 1 | Unclaimed-address pulse |

## Verification
The bench builds the decoder with its default of eight banks. With the fixed 128 KiB granule, this leaves exactly 32768 distinct decode inputs, so each bank configuration is swept over every granule. Three configurations are run:
- overlapping enabled windows next to a disabled one;
- the strap set, with a zero catch-all in bank 1;
- the strap set, with a parked nonzero bank 1.

Across these sweeps every mask bit, the priority order, both sides of the swap, and both miss and hit outcomes are reached against an arithmetic model kept in the bench.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int ADDR_W      = 32;
  localparam int GRAN_LSB    = 17;
  localparam int FLD_W       = ADDR_W - GRAN_LSB;
  localparam int REG_OFS_W   = 12;
  localparam int BANK_OFS    = 'h100;
  localparam int BANK_STRIDE = 'h10;
  localparam int NTIM        = 5;

  typedef struct packed {
    logic [FLD_W-1:0] base;
    logic             spare;
    logic [FLD_W-1:0] mask;
    logic             en;
  } bank_reg_t;

  function automatic logic [REG_OFS_W-1:0] bank_ofs(int i);
    return REG_OFS_W'(BANK_OFS + BANK_STRIDE * i);
  endfunction

  function automatic logic [REG_OFS_W-1:0] tim_ofs(int k);
    return (k < 4) ? REG_OFS_W'('h200 + 4 * k) : REG_OFS_W'('h300);
  endfunction

  function automatic logic is_catch_all(bank_reg_t r, logic low_bank);
    return low_bank && (r == '0);
  endfunction

  function automatic logic bank_match(bank_reg_t r, logic [FLD_W-1:0] gran, logic low_bank);
    return is_catch_all(r, low_bank) || (r.en && (((gran ^ r.base) & r.mask) == '0));
  endfunction

  function automatic int unsigned cs_of_reg(int unsigned r, logic swap);
    return (swap && r < 2) ? (r ^ 1) : r;
  endfunction
endpackage

// File: rtl/csel_regfile.sv
module csel_regfile
  import csel_pkg::*;
#(
  parameter int NBANK = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      boot_swap_i,
  input  logic                      we_i,
  input  logic [REG_OFS_W-1:0]      addr_i,
  input  logic [31:0]               wdata_i,
  output logic [31:0]               rdata_o,
  output bank_reg_t [NBANK-1:0]     banks_o,
  output logic                      swap_o
);
  bank_reg_t [NBANK-1:0] bank_q;
  logic [31:0]           tim_q [NTIM];
  logic                  swap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      swap_q <= boot_swap_i;
      for (int i = 0; i < NBANK; i++) bank_q[i] <= '0;
      bank_q[0].en <= ~boot_swap_i;
      for (int k = 0; k < NTIM; k++) tim_q[k] <= '0;
    end else if (we_i) begin
      for (int i = 0; i < NBANK; i++)
        if (addr_i == bank_ofs(i)) bank_q[i] <= bank_reg_t'(wdata_i);
      for (int k = 0; k < NTIM; k++)
        if (addr_i == tim_ofs(k)) tim_q[k] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NBANK; i++)
      if (addr_i == bank_ofs(i)) rdata_o = 32'(bank_q[i]);
    for (int k = 0; k < NTIM; k++)
      if (addr_i == tim_ofs(k)) rdata_o = tim_q[k];
  end

  assign banks_o = bank_q;
  assign swap_o  = swap_q;
endmodule

// File: rtl/csel_match.sv
module csel_match
  import csel_pkg::*;
#(
  parameter int NBANK = 8
) (
  input  bank_reg_t [NBANK-1:0] banks_i,
  input  logic [FLD_W-1:0]      gran_i,
  output logic [NBANK-1:0]      hit_vec_o,
  output logic                  catch_any_o
);
  logic [NBANK-1:0] catch_vec;

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    localparam logic LOW = (i < 2);
    assign hit_vec_o[i] = bank_match(banks_i[i], gran_i, LOW);
    assign catch_vec[i] = is_catch_all(banks_i[i], LOW);
  end

  assign catch_any_o = |catch_vec;
endmodule

// File: rtl/csel_arbiter.sv
module csel_arbiter
  import csel_pkg::*;
#(
  parameter int NBANK = 8,
  localparam int IDXW = $clog2(NBANK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic [NBANK-1:0] hit_vec_i,
  input  logic             swap_i,
  output logic [NBANK-1:0] cs_o,
  output logic [IDXW-1:0]  idx_o,
  output logic             hit_o,
  output logic             err_o
);
  logic [IDXW-1:0]  win;
  logic [IDXW-1:0]  idx_d;
  logic [NBANK-1:0] cs_d;
  logic             any;

  always_comb begin
    any = |hit_vec_i;
    win = '0;
    for (int i = NBANK - 1; i >= 0; i--)
      if (hit_vec_i[i]) win = IDXW'(i);
    idx_d = any ? IDXW'(cs_of_reg(32'(win), swap_i)) : '0;
    cs_d = '0;
    cs_d[idx_d] = any;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_o  <= '0;
      idx_o <= '0;
      hit_o <= 1'b0;
      err_o <= 1'b0;
    end else begin
      cs_o  <= valid_i ? cs_d : '0;
      idx_o <= valid_i ? idx_d : '0;
      hit_o <= valid_i && any;
      err_o <= valid_i && !any;
    end
  end
endmodule

// File: rtl/csel_decoder.sv
module csel_decoder
  import csel_pkg::*;
#(
  parameter int NBANK = 8,
  localparam int IDXW = $clog2(NBANK)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 boot_swap_i,
  input  logic                 reg_we_i,
  input  logic [REG_OFS_W-1:0] reg_addr_i,
  input  logic [31:0]          reg_wdata_i,
  output logic [31:0]          reg_rdata_o,
  input  logic                 addr_valid_i,
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [NBANK-1:0]     cs_o,
  output logic [IDXW-1:0]      cs_idx_o,
  output logic                 hit_o,
  output logic                 dec_err_o
);
  bank_reg_t [NBANK-1:0] banks;
  logic                  swap_q;
  logic [NBANK-1:0]      hit_vec;
  logic                  catch_any;
  logic                  unused_low_bits;

  assign unused_low_bits = ^addr_i[GRAN_LSB-1:0];

  csel_regfile #(.NBANK(NBANK)) u_regs (
    .clk(clk), .rst_n(rst_n), .boot_swap_i(boot_swap_i),
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .banks_o(banks), .swap_o(swap_q)
  );

  csel_match #(.NBANK(NBANK)) u_match (
    .banks_i(banks), .gran_i(addr_i[ADDR_W-1:GRAN_LSB]),
    .hit_vec_o(hit_vec), .catch_any_o(catch_any)
  );

  csel_arbiter #(.NBANK(NBANK)) u_arb (
    .clk(clk), .rst_n(rst_n), .valid_i(addr_valid_i), .hit_vec_i(hit_vec),
    .swap_i(swap_q), .cs_o(cs_o), .idx_o(cs_idx_o), .hit_o(hit_o), .err_o(dec_err_o)
  );
endmodule

// File: rtl/csel_decoder_chk.sv
module csel_decoder_chk #(
  parameter int NBANK = 8,
  localparam int IDXW = $clog2(NBANK)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             addr_valid_i,
  input logic [NBANK-1:0] cs_o,
  input logic [IDXW-1:0]  cs_idx_o,
  input logic             hit_o,
  input logic             dec_err_o,
  input logic             swap_q,
  input logic             catch_any
);
  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_o)); // R10
  AST_IDX_NAMES_CS: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> cs_o[cs_idx_o]); // R10
  AST_ERR_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    dec_err_o |-> $past(addr_valid_i)); // R9
  AST_ERR_EXCLUDES_CS: assert property (@(posedge clk) disable iff (!rst_n)
    dec_err_o |-> (!hit_o && cs_o == '0)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_valid_i |=> (cs_o == '0 && !hit_o && !dec_err_o)); // R8
  AST_CATCH_ALL_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid_i && catch_any) |=> hit_o); // R5
  AST_SWAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(swap_q)); // R7
endmodule

bind csel_decoder csel_decoder_chk #(.NBANK(NBANK)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_valid_i(addr_valid_i), .cs_o(cs_o),
  .cs_idx_o(cs_idx_o), .hit_o(hit_o), .dec_err_o(dec_err_o),
  .swap_q(swap_q), .catch_any(catch_any)
);

// File: tb/sim_csel_decoder.sv
`timescale 1ns/1ps
module sim_csel_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_swap = 1'b0;
  logic        we = 1'b0;
  logic [11:0] raddr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        valid = 1'b0;
  logic [31:0] addr = '0;
  logic [7:0]  cs;
  logic [2:0]  idx;
  logic        hit, err;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] sh [8];
  logic        sh_swap;

  always #2.5 clk = ~clk;

  csel_decoder u0 (
    .clk(clk), .rst_n(rst_n), .boot_swap_i(boot_swap), .reg_we_i(we),
    .reg_addr_i(raddr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .addr_valid_i(valid), .addr_i(addr), .cs_o(cs), .cs_idx_o(idx),
    .hit_o(hit), .dec_err_o(err)
  );

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] outs();
    return {19'b0, cs, idx, hit, err};
  endfunction

  task automatic do_reset(logic strap);
    @(negedge clk);
    rst_n = 0; boot_swap = strap; valid = 0; we = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 8; i++) sh[i] = '0;
    sh[0] = {31'b0, ~strap};
    sh_swap = strap;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1; raddr = a; wdata = d;
    @(negedge clk);
    we = 0;
    if (a >= 12'h100 && a < 12'h180 && a[3:0] == 4'h0) sh[a[6:4]] = d;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string rq);
    @(negedge clk);
    raddr = a;
    #1 chk(rq, rdata, exp);
  endtask

  task automatic model(input logic [31:0] a, output logic [31:0] e, output string rq);
    int win = -1;
    int nm = 0;
    int c;
    logic [14:0] g = a[31:17];
    for (int r = 0; r < 8; r++) begin
      logic [31:0] v = sh[r];
      logic ok = (r < 2 && v == 32'd0) ||
                 (v[0] && ((g & v[15:1]) == (v[31:17] & v[15:1])));
      if (ok) begin
        nm++;
        if (win < 0) win = r;
      end
    end
    if (win < 0) begin
      e = 32'd1; rq = "R9";
    end else begin
      c = (sh_swap && win < 2) ? 1 - win : win;
      e = {19'b0, 8'(1 << c), 3'(c), 1'b1, 1'b0};
      if (win < 2 && sh[win] == 32'd0) rq = "R5";
      else if (sh_swap && win < 2) rq = "R7";
      else if (nm > 1) rq = "R6";
      else rq = "R3";
    end
  endtask

  task automatic one(logic [31:0] a, string tag);
    logic [31:0] e;
    string rq;
    model(a, e, rq);
    @(negedge clk);
    addr = a; valid = 1;
    @(negedge clk);
    valid = 0;
    chk({tag, "/", rq}, outs(), e);
  endtask

  task automatic sweep();
    logic [31:0] e;
    logic [31:0] a;
    string rq;
    bit pend = 0;
    for (int g = 0; g < 32768; g++) begin
      @(negedge clk);
      if (pend) chk(rq, outs(), e);
      a = {15'(g), 17'((g * 7) & 'h1FFFF)};
      model(a, e, rq);
      addr = a; valid = 1; pend = 1;
    end
    @(negedge clk);
    chk(rq, outs(), e);
    valid = 0;
    @(negedge clk);
    chk("R8 idle", outs(), 32'd0);
  endtask

  initial begin
    do_reset(1'b0);
    // R1: reset state with strap low
    chk("R1 outputs", outs(), 32'd0);
    rd(12'h100, 32'h0000_0001, "R1 bank0");
    rd(12'h130, 32'h0, "R1 bank3");
    rd(12'h300, 32'h0, "R1 timing");
    // R2: timing words, unmapped offsets
    for (int k = 0; k < 5; k++) wr(k < 4 ? 12'(12'h200 + 4 * k) : 12'h300, 32'hA5A5_0000 + k);
    for (int k = 0; k < 5; k++) rd(k < 4 ? 12'(12'h200 + 4 * k) : 12'h300, 32'hA5A5_0000 + k, "R2 timing");
    wr(12'h210, 32'hDEAD_BEEF);
    wr(12'h104, 32'hDEAD_BEEF);
    rd(12'h210, 32'h0, "R2 unmapped");
    rd(12'h104, 32'h0, "R2 unmapped");
    rd(12'h100, 32'h0000_0001, "R2 bank0 untouched");
    // R11: timing writes left the reset decode intact (bank0 covers all)
    one(32'h1234_5678, "R11");
    // Config A: overlapping windows, disabled bank, parked banks 0/1
    wr(12'h100, 32'hFFFF_FFFF);
    wr(12'h110, 32'hFFFF_FFFF);
    wr(12'h120, 32'h0000_FFFF);
    wr(12'h130, 32'h4000_C001);
    wr(12'h140, 32'h0000_8001);
    wr(12'h150, 32'h8000_8000);
    wr(12'h170, 32'h9000_F001);
    rd(12'h130, 32'h4000_C001, "R2 bank3");
    one(32'h8000_0000, "R4 disabled bank5");
    one(32'h4000_0000, "R6 bank3 over bank4");
    sweep();
    // Config B: strap high, zero catch-all in bank 1
    do_reset(1'b1);
    rd(12'h100, 32'h0, "R1 strap high");
    one(32'h0000_0000, "R7 swap catch-all");
    wr(12'h100, 32'hFFFF_FFFF);
    wr(12'h120, 32'h0000_FFFF);
    sweep();
    // Config C: strap high, parked nonzero disabled bank 1
    do_reset(1'b1);
    wr(12'h100, 32'h8000_8001);
    wr(12'h110, 32'hFFFF_FFFE);
    wr(12'h120, 32'h4000_C001);
    one(32'h0100_0000, "R4 bank1 disabled nonzero");
    sweep();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #950000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule